// File: doc/BRIEF.md
# Stuck Clock Loss Detector

This block watches a set of externally supplied clocks from a free-running reference clock and reports any that has stopped. A monitored clock counts as stopped when it has had no rising edge for a fixed number of reference cycles. The line may be parked high or parked low; both cases are caught. Each monitored clock drives a toggle flop in its own domain. The toggle passes through a two-flop synchronizer into the reference domain, and every edge seen there restarts that channel's quiet-time counter.

Each channel has a live loss bit and a sticky change flag. The change flag is set whenever the loss bit changes in either direction and is cleared by writing one. Each channel also has an interrupt line that is raised only while its mask bit is set. A combined interrupt ORs the per-channel lines. At a 50 MHz reference the default window of 2048 cycles is about 41 µs. That is above the 10 µs lower limit and below the 125 µs upper limit.

Top module: `clk_loss_monitor`

## Requirements
- R1: After a synchronous active-low reset, `loss_o`, `delta_o`, `irq_o` and `irq_any_o` are all zero.
- R2: `loss_o[k]` goes to 1 when monitored clock k has had no rising edge for TIMEOUT_CYC reference cycles. While clock k keeps toggling, with every gap between rising edges shorter than TIMEOUT_CYC − 40 cycles, `loss_o[k]` stays 0.
- R3: A monitored clock parked at logic 1 and a monitored clock parked at logic 0 are both reported as lost.
- R4: Once clock k is lost, its first rising edge that is seen again returns `loss_o[k]` to 0 within 10 reference cycles.
- R5: Each change of `loss_o[k]`, whether to 1 or to 0, sets `delta_o[k]` on the same clock edge. `delta_o[k]` then holds until it is cleared.
- R6: Driving `clr_i[k]` high for one cycle clears `delta_o[k]` on that edge. Bit k of `clr_i` affects only channel k.
- R7: When a loss change on channel k and `clr_i[k]` fall on the same edge, `delta_o[k]` ends up 1.
- R8: `irq_o[k]` is 1 exactly when both `delta_o[k]` and `mask_i[k]` are 1. `irq_any_o` is the OR of all bits of `irq_o`.
- R9: Channels are independent. Stopping one monitored clock leaves the loss and delta bits of the others unchanged.
- R10: `loss_o[k]` rises no earlier than TIMEOUT_CYC reference cycles after the last rising edge of clock k. It rises no later than TIMEOUT_CYC + 5 reference cycles after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref_i | input | 1 | Free-running reference clock |
| rst_n_i | input | 1 | Synchronous active-low reset, reference domain |
| mon_clk_i | input | NUM_CLK | Monitored clocks, one per channel |
| mask_i | input | NUM_CLK | Interrupt enable per channel (1 = enabled) |
| clr_i | input | NUM_CLK | Write-one-to-clear strobes for the change flags |
| loss_o | output | NUM_CLK | Live loss state per channel (1 = stopped) |
| delta_o | output | NUM_CLK | Sticky change flags |
| irq_o | output | NUM_CLK | Masked per-channel interrupts |
| irq_any_o | output | 1 | OR of all per-channel interrupts |

## Verification
The hardest case to reach from the ports is a loss change that lands on the same reference edge as a clear strobe. That edge sits several synchronizer stages behind the stimulus, so its exact cycle is not known. The bench holds the clear strobe high for the whole loss transition. It then watches for the one-cycle pulse on the change flag that only the new change winning can produce. The edges of the detection window are checked the same way: checks are placed just inside and just outside the window, with margins that allow for the bench clock's half-period and for synchronizer latency. Random gaps, park levels, clock rates and masks fill in between these checks.

// File: rtl/clkmon_pkg.sv
// Shared types for the stuck clock loss detector.
package clkmon_pkg;

    // Per-channel output of the quiet-time timer.
    typedef struct packed {
        logic loss;    // live loss state
        logic change;  // loss state flips at the coming edge
    } chan_state_t;

endpackage

// File: rtl/clkmon_toggle.sv
// Monitored-domain toggle flop.
// Flips on every rising edge of the monitored clock, so activity turns into
// level changes that a slower or unrelated clock can sample safely.
// Assumes: no reset exists in the monitored domain, so the power-up value
// comes from the declaration; only changes matter downstream.
module clkmon_toggle (
    input  logic mon_clk_i,
    output logic tgl_o
);

    logic tgl_q = 1'b0;

    // Invert once per monitored rising edge.
    always_ff @(posedge mon_clk_i) begin
        tgl_q <= ~tgl_q;
    end

    assign tgl_o = tgl_q;

endmodule

// File: rtl/clkmon_sync.sv
// Two-flop synchronizer plus change detector in the reference domain.
// Emits a one-cycle pulse each time the synchronized toggle changes level.
// Assumes: the toggle holds each level for at least one reference period.
module clkmon_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic tgl_i,
    output logic edge_o
);

    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // Shift the asynchronous toggle through the synchronizer chain.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], tgl_i};
        end
    end

    // Keep the previous synchronized level for change detection.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign edge_o = sync_q[STAGES-1] ^ prev_q;

endmodule

// File: rtl/clkmon_timer.sv
// Per-channel quiet-time counter.
// Counts reference cycles since the last synchronized edge. When
// TIMEOUT_CYC cycles pass with no edge, loss is declared. The first edge
// after that clears it.
// Assumes: edge_i is a single-cycle pulse in the reference domain.
module clkmon_timer
    import clkmon_pkg::*;
#(
    parameter int TIMEOUT_CYC = 2048
) (
    input  logic        clk_i,
    input  logic        rst_n_i,
    input  logic        edge_i,
    output chan_state_t state_o
);

    localparam int CW = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

    logic [CW-1:0] cnt_q, cnt_d;
    logic          loss_q, loss_d;

    // Next-state logic: an edge restarts the count; the count saturates at LAST.
    always_comb begin
        cnt_d  = cnt_q;
        loss_d = loss_q;
        if (edge_i) begin
            cnt_d  = '0;
            loss_d = 1'b0;
        end else if (cnt_q == LAST) begin
            loss_d = 1'b1;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    // Register the count and the loss state.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            cnt_q  <= '0;
            loss_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            loss_q <= loss_d;
        end
    end

    assign state_o.loss   = loss_q;
    assign state_o.change = loss_d ^ loss_q;

endmodule

// File: rtl/clkmon_report.sv
// Change flags and interrupt gating for all channels.
// Flags are set by a loss change and cleared by writing one; a change and a
// clear on the same edge leave the flag set.
// Assumes: change_i pulses on the edge where loss flips.
module clkmon_report #(
    parameter int NUM_CLK = 3
) (
    input  logic               clk_i,
    input  logic               rst_n_i,
    input  logic [NUM_CLK-1:0] change_i,
    input  logic [NUM_CLK-1:0] clr_i,
    input  logic [NUM_CLK-1:0] mask_i,
    output logic [NUM_CLK-1:0] delta_o,
    output logic [NUM_CLK-1:0] irq_o,
    output logic               irq_any_o
);

    logic [NUM_CLK-1:0] delta_q;

    // Sticky flags: clear first, then set, so a new change wins.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            delta_q <= '0;
        end else begin
            delta_q <= (delta_q & ~clr_i) | change_i;
        end
    end

    assign delta_o   = delta_q;
    assign irq_o     = delta_q & mask_i;
    assign irq_any_o = |irq_o;

endmodule

// File: rtl/clk_loss_monitor.sv
// Top: stuck clock loss detector for NUM_CLK monitored clocks.
// Each channel is a toggle flop in the monitored domain, a synchronizer, and
// a quiet-time timer. One report stage holds the change flags and the
// interrupts. Assumes: clk_ref_i is free-running. TIMEOUT_CYC sets the window
// (2048 cycles is about 41 us at 50 MHz).
module clk_loss_monitor
    import clkmon_pkg::*;
#(
    parameter int NUM_CLK     = 3,
    parameter int TIMEOUT_CYC = 2048,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk_ref_i,
    input  logic               rst_n_i,
    input  logic [NUM_CLK-1:0] mon_clk_i,
    input  logic [NUM_CLK-1:0] mask_i,
    input  logic [NUM_CLK-1:0] clr_i,
    output logic [NUM_CLK-1:0] loss_o,
    output logic [NUM_CLK-1:0] delta_o,
    output logic [NUM_CLK-1:0] irq_o,
    output logic               irq_any_o
);

    logic [NUM_CLK-1:0] tgl_w;
    logic [NUM_CLK-1:0] edge_w;
    logic [NUM_CLK-1:0] change_w;
    chan_state_t        state_w [NUM_CLK];

    // One detection chain per monitored clock.
    for (genvar k = 0; k < NUM_CLK; k++) begin : g_chan
        clkmon_toggle tgl_i (
            .mon_clk_i (mon_clk_i[k]),
            .tgl_o     (tgl_w[k])
        );

        clkmon_sync #(.STAGES(SYNC_STAGES)) sync_i (
            .clk_i   (clk_ref_i),
            .rst_n_i (rst_n_i),
            .tgl_i   (tgl_w[k]),
            .edge_o  (edge_w[k])
        );

        clkmon_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) timer_i (
            .clk_i   (clk_ref_i),
            .rst_n_i (rst_n_i),
            .edge_i  (edge_w[k]),
            .state_o (state_w[k])
        );

        assign loss_o[k]   = state_w[k].loss;
        assign change_w[k] = state_w[k].change;
    end

    clkmon_report #(.NUM_CLK(NUM_CLK)) report_i (
        .clk_i     (clk_ref_i),
        .rst_n_i   (rst_n_i),
        .change_i  (change_w),
        .clr_i     (clr_i),
        .mask_i    (mask_i),
        .delta_o   (delta_o),
        .irq_o     (irq_o),
        .irq_any_o (irq_any_o)
    );

endmodule

// File: rtl/clk_loss_monitor_chk.sv
// Property checker for clk_loss_monitor, bound to every instance of it.
// Keeps its own count of cycles since each synchronized edge.
module clk_loss_monitor_chk #(
    parameter int NUM_CLK     = 3,
    parameter int TIMEOUT_CYC = 2048
) (
    input logic               clk_i,
    input logic               rst_n_i,
    input logic [NUM_CLK-1:0] edge_i,
    input logic [NUM_CLK-1:0] loss_o,
    input logic [NUM_CLK-1:0] delta_o,
    input logic [NUM_CLK-1:0] irq_o,
    input logic               irq_any_o,
    input logic [NUM_CLK-1:0] mask_i,
    input logic [NUM_CLK-1:0] clr_i
);

    localparam int QW = $clog2(TIMEOUT_CYC + 1);

    for (genvar k = 0; k < NUM_CLK; k++) begin : g_chk
        logic [QW-1:0] quiet_q;

        // Cycles since the last edge on channel k, saturating at the window.
        always_ff @(posedge clk_i) begin
            if (!rst_n_i || edge_i[k]) begin
                quiet_q <= '0;
            end else if (quiet_q != QW'(TIMEOUT_CYC)) begin
                quiet_q <= quiet_q + 1'b1;
            end
        end

        p_full_window_r10: assert property (@(posedge clk_i) disable iff (!rst_n_i)
            $rose(loss_o[k]) |-> quiet_q >= QW'(TIMEOUT_CYC));

        p_edge_clears_r4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
            edge_i[k] |=> !loss_o[k]);

        p_change_flags_r5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
            (loss_o[k] != $past(loss_o[k])) |-> delta_o[k]);

        p_flag_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
            (delta_o[k] && !clr_i[k]) |=> delta_o[k]);

        p_clear_works_r6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
            (delta_o[k] && clr_i[k]) |=> (!delta_o[k] || (loss_o[k] != $past(loss_o[k]))));

        p_masked_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
            !mask_i[k] |-> !irq_o[k]);
    end

    p_any_has_source_r8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        irq_any_o |-> ((delta_o & mask_i) != '0));

endmodule

bind clk_loss_monitor clk_loss_monitor_chk #(
    .NUM_CLK     (NUM_CLK),
    .TIMEOUT_CYC (TIMEOUT_CYC)
) chk_i (
    .clk_i     (clk_ref_i),
    .rst_n_i   (rst_n_i),
    .edge_i    (edge_w),
    .loss_o    (loss_o),
    .delta_o   (delta_o),
    .irq_o     (irq_o),
    .irq_any_o (irq_any_o),
    .mask_i    (mask_i),
    .clr_i     (clr_i)
);

// File: tb/clk_loss_monitor_tb_top.sv
// Self-checking bench: directed window and priority cases plus seeded random gaps.
module clk_loss_monitor_tb_top;

    localparam int N  = 3;
    localparam int TO = 256;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] mon_vec;
    logic [N-1:0] mask = '0;
    logic [N-1:0] clr = '0;
    logic [N-1:0] loss, delta, irq;
    logic         irq_any;

    logic run  [N] = '{default: 1'b1};
    logic park [N] = '{default: 1'b0};
    int   half [N] = '{default: 9};

    int n_chk = 0;
    int n_bad = 0;

    logic         hold_clr = 1'b0;
    logic [N-1:0] seen_delta = '0;
    logic [N-1:0] seen_loss = '0;

    always #(5ns) clk = ~clk;

    // Monitored clock generators: toggle while running, otherwise park.
    for (genvar g = 0; g < N; g++) begin : g_gen
        logic lvl = 1'b0;
        always begin
            #(half[g] * 1ns);
            if (run[g]) lvl = ~lvl;
            else        lvl = park[g];
        end
        assign mon_vec[g] = lvl;
    end

    clk_loss_monitor #(.NUM_CLK(N), .TIMEOUT_CYC(TO)) dut_i (
        .clk_ref_i (clk),
        .rst_n_i   (rst_n),
        .mon_clk_i (mon_vec),
        .mask_i    (mask),
        .clr_i     (clr),
        .loss_o    (loss),
        .delta_o   (delta),
        .irq_o     (irq),
        .irq_any_o (irq_any)
    );

    // Port observers sampled away from the active edge.
    always @(negedge clk) begin
        seen_loss <= seen_loss | loss;
        if (hold_clr) seen_delta <= seen_delta | delta;
    end

    function automatic logic exp_loss(int gap);
        return gap > TO;
    endfunction

    function automatic logic [N:0] exp_irq(logic [N-1:0] d, logic [N-1:0] m);
        return {|(d & m), d & m};
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_all();
        clr = '1;
        cyc(1);
        clr = '0;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'hC10C5EED));
        half = '{9, 13, 17};
        cyc(4);
        chk("R1", "loss after reset", loss, 0);
        chk("R1", "delta after reset", delta, 0);
        chk("R1", "irq after reset", {irq_any, irq}, 0);
        rst_n = 1'b1;
        cyc(3 * TO);
        chk("R2", "no loss while running", seen_loss, 0);
        chk("R5", "no delta while running", delta, 0);

        // Channel 0 parked high: window edges, mask, clear, recovery.
        run[0] = 1'b0; park[0] = 1'b1;
        cyc(TO - 12);
        chk("R10", "ch0 not lost before window", loss[0], 0);
        cyc(26);
        chk("R3", "ch0 stuck high lost", loss[0], 1);
        chk("R9", "other channels unaffected", {loss[2:1], delta[2:1]}, 0);
        chk("R5", "ch0 delta on loss", delta[0], 1);
        chk("R8", "masked irq low", {irq_any, irq}, exp_irq(delta, mask));
        mask = 3'b001;
        cyc(1);
        chk("R8", "unmasked irq", {irq_any, irq}, exp_irq(delta, mask));
        clr = 3'b010;
        cyc(1);
        clr = '0;
        chk("R6", "clear of ch1 leaves ch0", delta[0], 1);
        clr = 3'b001;
        cyc(1);
        clr = '0;
        chk("R6", "ch0 delta cleared", delta[0], 0);
        chk("R8", "irq drops after clear", {irq_any, irq}, 0);
        run[0] = 1'b1;
        cyc(10);
        chk("R4", "ch0 recovers", loss[0], 0);
        chk("R5", "ch0 delta on recovery", delta[0], 1);
        clear_all();

        // Channel 1 parked low.
        seen_loss = '0;
        run[1] = 1'b0; park[1] = 1'b0;
        cyc(TO - 12);
        chk("R10", "ch1 not lost before window", loss[1], 0);
        cyc(26);
        chk("R3", "ch1 stuck low lost", loss[1], 1);
        chk("R9", "ch0 and ch2 untouched", {seen_loss[2], seen_loss[0]}, 0);
        run[1] = 1'b1;
        cyc(10);
        chk("R4", "ch1 recovers", loss[1], 0);
        clear_all();

        // Change and clear on the same edge: hold clear across the transition.
        seen_delta = '0;
        hold_clr = 1'b1;
        clr = '1;
        run[2] = 1'b0; park[2] = 1'b1;
        cyc(TO + 20);
        hold_clr = 1'b0;
        cyc(1);
        clr = '0;
        chk("R7", "change beats clear", seen_delta[2], 1);
        chk("R2", "ch2 lost under held clear", loss[2], 1);
        run[2] = 1'b1;
        cyc(12);
        clear_all();

        // Random gaps, park levels, rates and masks.
        for (int it = 0; it < 14; it++) begin
            int ch  = $urandom_range(0, N - 1);
            int gap;
            logic lng = 1'($urandom_range(0, 1));
            for (int j = 0; j < N; j++) half[j] = $urandom_range(7, 40);
            gap  = lng ? $urandom_range(TO + 20, 2 * TO) : $urandom_range(TO / 4, TO - 40);
            mask = N'($urandom_range(0, (1 << N) - 1));
            cyc(12);
            clear_all();
            seen_loss = '0;
            park[ch] = 1'($urandom_range(0, 1));
            run[ch]  = 1'b0;
            cyc(gap);
            run[ch]  = 1'b1;
            cyc(20);
            chk(lng ? "R2" : "R2", "random loss seen", seen_loss[ch], exp_loss(gap));
            chk("R5", "random delta", delta[ch], exp_loss(gap));
            chk("R4", "random recovered", loss[ch], 0);
            chk("R9", "random others quiet", seen_loss & ~(N'(1) << ch), 0);
            chk("R8", "random irq", {irq_any, irq}, exp_irq(delta, mask));
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule